// File: doc/BRIEF.md
# Channel-Buffered DRAM Command Spacing Monitor

This block watches the decoded command stream of a two-bank DRAM that stages data in a set of channel buffers. On every clock it takes one abstract command, the bank it addresses and the channel buffer it names. It keeps per-bank, per-channel and global "cycles since" timers. It reports the first spacing rule that a command breaks, whether the command came too early or a deadline passed. The monitor never blocks or alters traffic. It belongs next to a memory controller, either as a design-time checker or as a silicon watchdog on the command path.

Every minimum spacing is held in nanoseconds and converted to cycles by rounding up at the configured clock period. The default period is 7.5 ns. A restore followed closely by an activate forms a restore-activate pair. This pair opens a short guard window and brings in its own spacing limits on later prefetches, activates and channel accesses. When a violation is seen, a sticky flag and a code naming the broken rule are latched. They hold until a synchronous clear.

Top module: `vc_cmd_timing_chk`

## Requirements
- R1: Command encoding on `cmd` is: 0 idle, 1 activate, 2 precharge, 3 refresh, 4 prefetch, 5 prefetch with auto-precharge, 6 prefetch-read, 7 restore, 8 restore with auto-precharge, 9 read, 10 write, 11 mode-register set. After reset, `violFlag` is 0 and `violCode` is 0.
- R2: The first violation sets `violFlag` and latches its code. Later violations leave the code unchanged. A cycle with `clr` high returns both outputs to 0 after that edge.
- R3: An idle command is never checked. Any non-idle command issued fewer than 2 cycles after a mode-register set raises code 1.
- R4: Activate or refresh to a bank fewer than 9 cycles after an activate or refresh to the same bank raises code 4. Activate fewer than 2 cycles after an activate to the other bank raises code 15.
- R5: Precharge to an open bank fewer than 7 cycles after its activate raises code 5. A bank left open for more than 16000 cycles raises code 6. A precharge at exactly 16000 cycles is legal.
- R6: Activate or refresh fewer than 3 cycles after a precharge to the same bank raises code 7.
- R7: Any prefetch (codes 4, 5, 6) fewer than 2 cycles after an activate to the same bank raises code 8. Precharge fewer than 3 cycles after a plain prefetch to that bank raises code 9. Activate or refresh fewer than 6 cycles after a prefetch with auto-precharge or a prefetch-read to that bank raises code 10.
- R8: Prefetch or prefetch with auto-precharge fewer than 3 cycles after a plain prefetch raises code 13. Either restore fewer than 3 cycles after a prefetch or prefetch with auto-precharge raises code 14.
- R9: An activate 1 to 4 cycles after either restore is a restore-activate and raises nothing. If no activate arrives within 4 cycles, code 3 is raised in the fifth cycle.
- R10: While a restore awaits its activate, any other background command (precharge, refresh, any prefetch, any restore) raises code 2. A read or write to the restore's channel also raises code 2. A read or write to another channel is legal.
- R11: Any prefetch fewer than 5 cycles after a restore-activate raises code 11. A restore-activate fewer than 4 cycles after the previous restore-activate raises code 12.
- R12: A read or write to a channel fewer than 2 cycles after a prefetch or prefetch with auto-precharge to that channel raises code 16. One fewer than 4 cycles after a restore-activate of that channel raises code 17. Consecutive reads and writes have no spacing limit.
- R13: When several rules fail in the same cycle, the lowest code is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of flag and code |
| cmd | input | 4 | Command code (see R1) |
| bankSel | input | 1 | Bank addressed by the command |
| chanSel | input | $clog2(NUM_CH) | Channel buffer named by the command |
| violFlag | output | 1 | Sticky violation flag |
| violCode | output | 5 | Code of the first violated rule |

## Verification
A randomized pair sweep issues two commands at a random gap of 1 to 12 cycles for each rule. It catches a limit that is off by one cycle: a gap equal to the minimum would flag, or one a cycle short would pass. Directed restore sequences cover several cases. One is an activate at the window edge. Another is a missing activate, where a wrong window length makes the late code appear a cycle early or late. Others are channel accesses during and after the window, where a monitor that ignored the channel would accept or reject the wrong read. The open-bank deadline is tested on both sides of the 16000-cycle bound. Stacked failures show whether the lowest code is kept and whether the latched code stays fixed.

// File: rtl/vcdram_chk_pkg.sv
package vcdram_chk_pkg;

  localparam int NB = 2;

  typedef enum logic [3:0] {
    CMD_IDLE       = 4'd0,
    CMD_ACT        = 4'd1,
    CMD_PRE        = 4'd2,
    CMD_REF        = 4'd3,
    CMD_FETCH      = 4'd4,
    CMD_FETCH_AP   = 4'd5,
    CMD_FETCH_RD   = 4'd6,
    CMD_RESTORE    = 4'd7,
    CMD_RESTORE_AP = 4'd8,
    CMD_RD         = 4'd9,
    CMD_WR         = 4'd10,
    CMD_MODE       = 4'd11
  } cmd_e;

  localparam int NCODE = 18;

  // Spacing values in picoseconds
  localparam int unsigned ACT_CYCLE_PS   = 67500;
  localparam int unsigned ACT_PRE_MIN_PS = 52500;
  localparam int unsigned ACT_PRE_MAX_PS = 120000000;
  localparam int unsigned PRE_ACT_PS     = 20000;
  localparam int unsigned ACT_FETCH_PS   = 15000;
  localparam int unsigned FETCH_PRE_PS   = 22500;
  localparam int unsigned FETCHAP_ACT_PS = 45000;
  localparam int unsigned RESTORE_WIN_PS = 30000;
  localparam int unsigned RACT_FETCH_PS  = 37500;
  localparam int unsigned RACT_RACT_PS   = 30000;
  localparam int unsigned FETCH_FETCH_PS = 22500;
  localparam int unsigned FETCH_REST_PS  = 22500;
  localparam int unsigned ACT_XBANK_PS   = 15000;
  localparam int unsigned FETCH_RW_PS    = 15000;
  localparam int unsigned RACT_RW_PS     = 30000;
  localparam int unsigned MODE_GAP_CYC   = 2;

  function automatic int unsigned ceilCyc(int unsigned ps, int unsigned clkPs);
    return (ps + clkPs - 1) / clkPs;
  endfunction

  function automatic int unsigned floorCyc(int unsigned ps, int unsigned clkPs);
    return ps / clkPs;
  endfunction

  typedef struct packed {
    logic [NB-1:0] act;
    logic [NB-1:0] actRef;
    logic [NB-1:0] pre;
    logic [NB-1:0] fetch;
    logic [NB-1:0] fetchApRd;
    logic [NB-1:0] openClr;
    logic          restore;
    logic          ract;
    logic          pendClr;
    logic          fetchPlain;
    logic          fetchOrAp;
    logic          mode;
  } stb_t;

endpackage

// File: rtl/vc_sat_cnt.sv
module vc_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '1;
    else if (set)          cnt <= W'(1);
    else if (cnt != '1)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/vc_timer_dp.sv
module vc_timer_dp
  import vcdram_chk_pkg::*;
#(
  parameter int CW     = 15,
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  stb_t                  stb,
  input  logic [CH_W-1:0]       chanSel,
  output logic [NB-1:0][CW-1:0] sinceActRef,
  output logic [NB-1:0][CW-1:0] sinceAct,
  output logic [NB-1:0][CW-1:0] sincePre,
  output logic [NB-1:0][CW-1:0] sinceFetch,
  output logic [NB-1:0][CW-1:0] sinceFetchApRd,
  output logic [CW-1:0]         sinceRst,
  output logic [CW-1:0]         sinceRact,
  output logic [CW-1:0]         sinceFetchPlain,
  output logic [CW-1:0]         sinceFetchOrAp,
  output logic [CW-1:0]         sinceMode,
  output logic [CW-1:0]         chFetchCnt,
  output logic [CW-1:0]         chRactCnt,
  output logic [NB-1:0]         bankOpen,
  output logic                  rstPending,
  output logic [CH_W-1:0]       rstChan
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    vc_sat_cnt #(.W(CW)) uActRef (.clk(clk), .rst_n(rst_n), .set(stb.actRef[b]),    .cnt(sinceActRef[b]));
    vc_sat_cnt #(.W(CW)) uAct    (.clk(clk), .rst_n(rst_n), .set(stb.act[b]),       .cnt(sinceAct[b]));
    vc_sat_cnt #(.W(CW)) uPre    (.clk(clk), .rst_n(rst_n), .set(stb.pre[b]),       .cnt(sincePre[b]));
    vc_sat_cnt #(.W(CW)) uFetch  (.clk(clk), .rst_n(rst_n), .set(stb.fetch[b]),     .cnt(sinceFetch[b]));
    vc_sat_cnt #(.W(CW)) uFApRd  (.clk(clk), .rst_n(rst_n), .set(stb.fetchApRd[b]), .cnt(sinceFetchApRd[b]));

    always_ff @(posedge clk) begin
      if (!rst_n)                bankOpen[b] <= 1'b0;
      else if (stb.act[b])       bankOpen[b] <= 1'b1;
      else if (stb.openClr[b])   bankOpen[b] <= 1'b0;
    end

    assert_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stb.act[b] |=> bankOpen[b]) else $error("bank not open after activate");
  end

  vc_sat_cnt #(.W(CW)) uRst   (.clk(clk), .rst_n(rst_n), .set(stb.restore),    .cnt(sinceRst));
  vc_sat_cnt #(.W(CW)) uRact  (.clk(clk), .rst_n(rst_n), .set(stb.ract),       .cnt(sinceRact));
  vc_sat_cnt #(.W(CW)) uFPl   (.clk(clk), .rst_n(rst_n), .set(stb.fetchPlain), .cnt(sinceFetchPlain));
  vc_sat_cnt #(.W(CW)) uFOA   (.clk(clk), .rst_n(rst_n), .set(stb.fetchOrAp),  .cnt(sinceFetchOrAp));
  vc_sat_cnt #(.W(CW)) uMode  (.clk(clk), .rst_n(rst_n), .set(stb.mode),       .cnt(sinceMode));

  logic [CW-1:0] chFetch [NUM_CH];
  logic [CW-1:0] chRact  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic setF, setR;
    assign setF = stb.fetchOrAp && (chanSel == CH_W'(c));
    assign setR = stb.ract && (rstChan == CH_W'(c));
    vc_sat_cnt #(.W(CW)) uChF (.clk(clk), .rst_n(rst_n), .set(setF), .cnt(chFetch[c]));
    vc_sat_cnt #(.W(CW)) uChR (.clk(clk), .rst_n(rst_n), .set(setR), .cnt(chRact[c]));
  end

  assign chFetchCnt = chFetch[chanSel];
  assign chRactCnt  = chRact[chanSel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rstPending <= 1'b0;
      rstChan    <= '0;
    end else if (stb.restore) begin
      rstPending <= 1'b1;
      rstChan    <= chanSel;
    end else if (stb.pendClr) begin
      rstPending <= 1'b0;
    end
  end

  assert_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb.restore |=> rstPending) else $error("restore not pending");

endmodule

// File: rtl/vc_rule_ctrl.sv
module vc_rule_ctrl
  import vcdram_chk_pkg::*;
#(
  parameter int          CW     = 15,
  parameter int          CH_W   = 4,
  parameter int unsigned CLK_PS = 7500
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [3:0]            cmdIn,
  input  logic                  bankSel,
  input  logic [CH_W-1:0]       chanSel,
  input  logic [NB-1:0][CW-1:0] sinceActRef,
  input  logic [NB-1:0][CW-1:0] sinceAct,
  input  logic [NB-1:0][CW-1:0] sincePre,
  input  logic [NB-1:0][CW-1:0] sinceFetch,
  input  logic [NB-1:0][CW-1:0] sinceFetchApRd,
  input  logic [CW-1:0]         sinceRst,
  input  logic [CW-1:0]         sinceRact,
  input  logic [CW-1:0]         sinceFetchPlain,
  input  logic [CW-1:0]         sinceFetchOrAp,
  input  logic [CW-1:0]         sinceMode,
  input  logic [CW-1:0]         chFetchCnt,
  input  logic [CW-1:0]         chRactCnt,
  input  logic [NB-1:0]         bankOpen,
  input  logic                  rstPending,
  input  logic [CH_W-1:0]       rstChan,
  output stb_t                  stb,
  output logic                  violFlag,
  output logic [4:0]            violCode
);

  localparam logic [CW-1:0] T_CYCLE   = CW'(ceilCyc(ACT_CYCLE_PS,   CLK_PS));
  localparam logic [CW-1:0] T_RASMIN  = CW'(ceilCyc(ACT_PRE_MIN_PS, CLK_PS));
  localparam logic [CW-1:0] T_RASMAX  = CW'(floorCyc(ACT_PRE_MAX_PS, CLK_PS));
  localparam logic [CW-1:0] T_RASLIM  = T_RASMAX + CW'(1);
  localparam logic [CW-1:0] T_PREACT  = CW'(ceilCyc(PRE_ACT_PS,     CLK_PS));
  localparam logic [CW-1:0] T_ACTF    = CW'(ceilCyc(ACT_FETCH_PS,   CLK_PS));
  localparam logic [CW-1:0] T_FPRE    = CW'(ceilCyc(FETCH_PRE_PS,   CLK_PS));
  localparam logic [CW-1:0] T_FAPACT  = CW'(ceilCyc(FETCHAP_ACT_PS, CLK_PS));
  localparam logic [CW-1:0] T_WIN     = CW'(floorCyc(RESTORE_WIN_PS, CLK_PS));
  localparam logic [CW-1:0] T_WINLIM  = T_WIN + CW'(1);
  localparam logic [CW-1:0] T_RAF     = CW'(ceilCyc(RACT_FETCH_PS,  CLK_PS));
  localparam logic [CW-1:0] T_RARA    = CW'(ceilCyc(RACT_RACT_PS,   CLK_PS));
  localparam logic [CW-1:0] T_FF      = CW'(ceilCyc(FETCH_FETCH_PS, CLK_PS));
  localparam logic [CW-1:0] T_FREST   = CW'(ceilCyc(FETCH_REST_PS,  CLK_PS));
  localparam logic [CW-1:0] T_XBANK   = CW'(ceilCyc(ACT_XBANK_PS,   CLK_PS));
  localparam logic [CW-1:0] T_FRW     = CW'(ceilCyc(FETCH_RW_PS,    CLK_PS));
  localparam logic [CW-1:0] T_RARW    = CW'(ceilCyc(RACT_RW_PS,     CLK_PS));
  localparam logic [CW-1:0] T_MODE    = CW'(MODE_GAP_CYC);

  cmd_e cmd;
  assign cmd = cmd_e'(cmdIn);

  logic isAct, isPre, isRef, isFetch, isFetchAp, isFetchRd, isRestore, isFg, isAny;
  logic isFetchAll, isBg, late, inWin, ract, actOrRef;
  logic [NB-1:0] bankHit, rasFire;
  logic [NCODE-1:0] fail;
  logic [4:0] firstCode;

  assign isAct      = (cmd == CMD_ACT);
  assign isPre      = (cmd == CMD_PRE);
  assign isRef      = (cmd == CMD_REF);
  assign isFetch    = (cmd == CMD_FETCH);
  assign isFetchAp  = (cmd == CMD_FETCH_AP);
  assign isFetchRd  = (cmd == CMD_FETCH_RD);
  assign isRestore  = (cmd == CMD_RESTORE) || (cmd == CMD_RESTORE_AP);
  assign isFg       = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign isAny      = (cmd != CMD_IDLE);
  assign isFetchAll = isFetch || isFetchAp || isFetchRd;
  assign isBg       = isPre || isRef || isFetchAll || isRestore;
  assign actOrRef   = isAct || isRef;
  assign late       = rstPending && (sinceRst > T_WIN);
  assign inWin      = rstPending && !late;
  assign ract       = isAct && inWin;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bankHit[b] = (bankSel == 1'(b));
    assign rasFire[b] = bankOpen[b] && (sinceAct[b] > T_RASMAX);

    assert_ras_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bankOpen[b] |-> (sinceAct[b] <= T_RASLIM)) else $error("open bank past deadline");
  end

  always_comb begin
    stb            = '0;
    stb.act        = bankHit & {NB{isAct}};
    stb.actRef     = bankHit & {NB{actOrRef}};
    stb.pre        = bankHit & {NB{isPre}};
    stb.fetch      = bankHit & {NB{isFetch}};
    stb.fetchApRd  = bankHit & {NB{isFetchAp || isFetchRd}};
    stb.openClr    = (bankHit & {NB{isPre || isFetchAp}}) | rasFire;
    stb.restore    = isRestore;
    stb.ract       = ract;
    stb.pendClr    = ract || late;
    stb.fetchPlain = isFetch;
    stb.fetchOrAp  = isFetch || isFetchAp;
    stb.mode       = (cmd == CMD_MODE);
  end

  always_comb begin
    fail     = '0;
    fail[1]  = isAny && (sinceMode < T_MODE);
    fail[2]  = inWin && (isBg || (isFg && (chanSel == rstChan)));
    fail[3]  = late;
    fail[4]  = actOrRef && (sinceActRef[bankSel] < T_CYCLE);
    fail[5]  = isPre && bankOpen[bankSel] && (sinceAct[bankSel] < T_RASMIN);
    fail[6]  = |rasFire;
    fail[7]  = actOrRef && (sincePre[bankSel] < T_PREACT);
    fail[8]  = isFetchAll && (sinceAct[bankSel] < T_ACTF);
    fail[9]  = isPre && (sinceFetch[bankSel] < T_FPRE);
    fail[10] = actOrRef && (sinceFetchApRd[bankSel] < T_FAPACT);
    fail[11] = isFetchAll && (sinceRact < T_RAF);
    fail[12] = ract && (sinceRact < T_RARA);
    fail[13] = (isFetch || isFetchAp) && (sinceFetchPlain < T_FF);
    fail[14] = isRestore && (sinceFetchOrAp < T_FREST);
    fail[15] = isAct && (sinceAct[~bankSel] < T_XBANK);
    fail[16] = isFg && (chFetchCnt < T_FRW);
    fail[17] = isFg && (chRactCnt < T_RARW);
  end

  // Lowest failing rule wins (R13)
  always_comb begin
    firstCode = '0;
    for (int i = NCODE - 1; i >= 1; i--) begin
      if (fail[i]) firstCode = 5'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      violFlag <= 1'b0;
      violCode <= '0;
    end else if (!violFlag && (|fail)) begin
      violFlag <= 1'b1;
      violCode <= firstCode;
    end
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (violFlag && !clr) |=> (violFlag && $stable(violCode))) else $error("flag or code moved");

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!violFlag && (violCode == 5'd0))) else $error("clear ignored");

  assert_window_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rstPending |-> (sinceRst <= T_WINLIM)) else $error("restore window overran");

  assert_code_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    violFlag |-> (violCode != 5'd0)) else $error("flag without code");

endmodule

// File: rtl/vc_cmd_timing_chk.sv
module vc_cmd_timing_chk
  import vcdram_chk_pkg::*;
#(
  parameter int unsigned CLK_PS = 7500,
  parameter int          NUM_CH = 16,
  localparam int         CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [3:0]      cmd,
  input  logic            bankSel,
  input  logic [CH_W-1:0] chanSel,
  output logic            violFlag,
  output logic [4:0]      violCode
);

  localparam int RAS_MAX_CYC = int'(floorCyc(ACT_PRE_MAX_PS, CLK_PS));
  localparam int CW          = $clog2(RAS_MAX_CYC + 2) + 1;

  stb_t stb;
  logic [NB-1:0][CW-1:0] sinceActRef, sinceAct, sincePre, sinceFetch, sinceFetchApRd;
  logic [CW-1:0] sinceRst, sinceRact, sinceFetchPlain, sinceFetchOrAp, sinceMode;
  logic [CW-1:0] chFetchCnt, chRactCnt;
  logic [NB-1:0] bankOpen;
  logic          rstPending;
  logic [CH_W-1:0] rstChan;

  vc_timer_dp #(.CW(CW), .NUM_CH(NUM_CH), .CH_W(CH_W)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .chanSel(chanSel),
    .sinceActRef(sinceActRef), .sinceAct(sinceAct), .sincePre(sincePre),
    .sinceFetch(sinceFetch), .sinceFetchApRd(sinceFetchApRd),
    .sinceRst(sinceRst), .sinceRact(sinceRact), .sinceFetchPlain(sinceFetchPlain),
    .sinceFetchOrAp(sinceFetchOrAp), .sinceMode(sinceMode),
    .chFetchCnt(chFetchCnt), .chRactCnt(chRactCnt),
    .bankOpen(bankOpen), .rstPending(rstPending), .rstChan(rstChan)
  );

  vc_rule_ctrl #(.CW(CW), .CH_W(CH_W), .CLK_PS(CLK_PS)) uCtrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmdIn(cmd), .bankSel(bankSel), .chanSel(chanSel),
    .sinceActRef(sinceActRef), .sinceAct(sinceAct), .sincePre(sincePre),
    .sinceFetch(sinceFetch), .sinceFetchApRd(sinceFetchApRd),
    .sinceRst(sinceRst), .sinceRact(sinceRact), .sinceFetchPlain(sinceFetchPlain),
    .sinceFetchOrAp(sinceFetchOrAp), .sinceMode(sinceMode),
    .chFetchCnt(chFetchCnt), .chRactCnt(chRactCnt),
    .bankOpen(bankOpen), .rstPending(rstPending), .rstChan(rstChan),
    .stb(stb), .violFlag(violFlag), .violCode(violCode)
  );

endmodule

// File: tb/tb_vc_cmd_timing_chk.sv
module tb_vc_cmd_timing_chk;

  localparam logic [3:0] IDLE = 0, ACT = 1, PRE = 2, REF = 3, PF = 4, PFAP = 5, PFRD = 6,
                         RS = 7, RSAP = 8, RD = 9, WR = 10, MODE = 11;

  logic clk = 1'b0;
  logic rst_n, clr, bankSel;
  logic [3:0] cmd, chanSel;
  logic violFlag;
  logic [4:0] violCode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vc_cmd_timing_chk dut (.clk(clk), .rst_n(rst_n), .clr(clr), .cmd(cmd), .bankSel(bankSel),
                         .chanSel(chanSel), .violFlag(violFlag), .violCode(violCode));

  task automatic issue(logic [3:0] c, logic b, logic [3:0] ch);
    cmd = c; bankSel = b; chanSel = ch;
    @(posedge clk); #2;
    cmd = IDLE;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(IDLE, 1'b0, 4'd0);
  endtask

  task automatic doReset();
    rst_n = 1'b0; clr = 1'b0; cmd = IDLE; bankSel = 1'b0; chanSel = '0;
    @(posedge clk); #2; @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  task automatic check(string req, logic expFlag, int expCode);
    checks++;
    if (violFlag !== expFlag || violCode !== 5'(expCode)) begin
      errors++;
      $display("FAIL %s: flag %0b code %0d, expected flag %0b code %0d",
               req, violFlag, violCode, expFlag, expCode);
    end
  endtask

  // Pair rule table: first command, second command, banks, channel, min gap, code
  function automatic logic [3:0] pairA(int p);
    case (p)
      0: return ACT;  1: return ACT;  2: return PRE;  3: return ACT;  4: return PF;
      5: return PFAP; 6: return PF;   7: return ACT;  8: return MODE; 9: return REF;
      10: return PF;  default: return PF;
    endcase
  endfunction
  function automatic logic [3:0] pairB(int p);
    case (p)
      0: return ACT;  1: return PRE;  2: return ACT;  3: return PF;   4: return PRE;
      5: return ACT;  6: return PF;   7: return ACT;  8: return PRE;  9: return REF;
      10: return RD;  default: return RS;
    endcase
  endfunction
  function automatic logic pairBankB(int p);
    return (p == 7);
  endfunction
  function automatic int pairMin(int p);
    case (p)
      0: return 9;  1: return 7;  2: return 3;  3: return 2;  4: return 3;  5: return 6;
      6: return 3;  7: return 2;  8: return 2;  9: return 9;  10: return 2; default: return 3;
    endcase
  endfunction
  function automatic int pairCode(int p);
    case (p)
      0: return 4;  1: return 5;  2: return 7;  3: return 8;  4: return 9;  5: return 10;
      6: return 13; 7: return 15; 8: return 1;  9: return 4;  10: return 16; default: return 14;
    endcase
  endfunction
  function automatic string pairReq(int p);
    case (p)
      0, 7, 9: return "R4";  1: return "R5";  2: return "R6";  3, 4, 5: return "R7";
      6, 11: return "R8";  8: return "R3";  default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    doReset();
    check("R1 reset", 1'b0, 0);

    // Random pair sweep across rules
    for (int it = 0; it < 48; it++) begin
      int p, g;
      p = int'($urandom % 12);
      g = 1 + int'($urandom % 12);
      doReset();
      issue(pairA(p), 1'b0, 4'd3);
      idle(g - 1);
      issue(pairB(p), pairBankB(p), 4'd3);
      check(pairReq(p), g < pairMin(p), (g < pairMin(p)) ? pairCode(p) : 0);
    end

    // Directed pair boundaries
    for (int p = 0; p < 12; p++) begin
      for (int d = -1; d <= 0; d++) begin
        int g;
        g = pairMin(p) + d;
        doReset();
        issue(pairA(p), 1'b0, 4'd3);
        idle(g - 1);
        issue(pairB(p), pairBankB(p), 4'd3);
        check(pairReq(p), d < 0, (d < 0) ? pairCode(p) : 0);
      end
    end

    // R3: idle after mode set never checked
    doReset();
    issue(MODE, 1'b0, 4'd0);
    issue(IDLE, 1'b0, 4'd0);
    check("R3 idle unchecked", 1'b0, 0);
    issue(PRE, 1'b0, 4'd0);
    check("R3 gap 2 legal", 1'b0, 0);

    // R9 and R12: restore-activate at gap 2, read at gap 4, then back-to-back write
    doReset();
    issue(RS, 1'b0, 4'd5);
    idle(1);
    issue(ACT, 1'b0, 4'd5);
    check("R9 restore-activate", 1'b0, 0);
    idle(3);
    issue(RD, 1'b0, 4'd5);
    issue(WR, 1'b0, 4'd5);
    check("R12 read/write after restore-activate", 1'b0, 0);

    // R9: activate at window edge (gap 4)
    doReset();
    issue(RSAP, 1'b0, 4'd2);
    idle(3);
    issue(ACT, 1'b1, 4'd2);
    check("R9 window edge", 1'b0, 0);
    idle(6);
    check("R9 no late after activate", 1'b0, 0);

    // R9: late restore
    doReset();
    issue(RS, 1'b0, 4'd5);
    idle(4);
    check("R9 within window", 1'b0, 0);
    idle(1);
    check("R9 late", 1'b1, 3);

    // R12: read too soon after restore-activate
    doReset();
    issue(RS, 1'b0, 4'd5);
    issue(ACT, 1'b0, 4'd5);
    idle(1);
    issue(RD, 1'b0, 4'd5);
    check("R12 read after restore-activate", 1'b1, 17);

    // R10: background in window
    doReset();
    issue(RS, 1'b0, 4'd5);
    issue(PRE, 1'b1, 4'd0);
    check("R10 background in window", 1'b1, 2);

    // R10: same-channel read in window
    doReset();
    issue(RS, 1'b0, 4'd5);
    issue(RD, 1'b0, 4'd5);
    check("R10 same channel read", 1'b1, 2);

    // R10: other channel read legal, then activate
    doReset();
    issue(RS, 1'b0, 4'd5);
    issue(RD, 1'b0, 4'd6);
    issue(ACT, 1'b0, 4'd0);
    check("R10 other channel read", 1'b0, 0);

    // R11: restore-activate to restore-activate
    doReset();
    issue(RS, 1'b0, 4'd5);
    issue(ACT, 1'b0, 4'd5);
    issue(RS, 1'b0, 4'd6);
    issue(ACT, 1'b1, 4'd6);
    check("R11 restore-activate pair", 1'b1, 12);

    // R11: prefetch too soon after restore-activate
    doReset();
    issue(RS, 1'b0, 4'd5);
    issue(ACT, 1'b0, 4'd5);
    idle(1);
    issue(PF, 1'b0, 4'd5);
    check("R11 prefetch after restore-activate", 1'b1, 11);

    // R13: mode gap and activate cycle fail together
    doReset();
    issue(ACT, 1'b0, 4'd0);
    idle(3);
    issue(MODE, 1'b0, 4'd0);
    issue(ACT, 1'b0, 4'd0);
    check("R13 lowest code", 1'b1, 1);

    // R2: sticky first code, then clear
    doReset();
    issue(ACT, 1'b0, 4'd0);
    issue(ACT, 1'b0, 4'd0);
    check("R2 first violation", 1'b1, 4);
    issue(PRE, 1'b0, 4'd0);
    check("R2 code held", 1'b1, 4);
    clr = 1'b1;
    issue(IDLE, 1'b0, 4'd0);
    clr = 1'b0;
    check("R2 clear", 1'b0, 0);

    // R5: open-bank deadline
    doReset();
    issue(ACT, 1'b0, 4'd0);
    idle(15999);
    issue(PRE, 1'b0, 4'd0);
    check("R5 precharge at limit", 1'b0, 0);
    doReset();
    issue(ACT, 1'b1, 4'd0);
    idle(16000);
    check("R5 open at limit", 1'b0, 0);
    idle(1);
    check("R5 open too long", 1'b1, 6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule